// File: doc/BRIEF.md
# DDR2 Data-Lane Termination Enable Sequencer

This block sits on the controller side of a single-rank DDR2 interface. It drives the pin that switches the memory device's on-die termination. The termination is switched on while the device receives write data and switched off while the device drives read data. The block also produces the extended-mode-register word that selects the termination resistance. It is only concerned with the data, strobe and mask lanes. Address and command lines get no enable from it.

An initialisation request makes the block issue a one-cycle mode-register load pulse. The pulse carries a 16-bit word that addresses the extended mode register and holds the resistance code. A fixed settling time later, a one-cycle done pulse follows. Until that done pulse the termination enable stays low and commands are disregarded. After that, a stream of read and write command strobes shapes the enable, using the configured write and read latencies and burst length. Two run-time knobs adjust the timing: a lead (cycles of enable before the first write beat) and a tail (cycles kept after the last beat).

Top module: `term_enable_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `odt_en`, `emr_load` and `init_done` are all low.
- R2: If `init_req` is high in a cycle while no load is in progress, `emr_load` is high for exactly the next cycle. In that cycle `emr_word` has bits [15:14] = 01 and all bits other than 15:14, 6 and 2 at zero.
- R3: The resistance code `rtt_sel` is placed as bit 6 = `rtt_sel[1]` and bit 2 = `rtt_sel[0]`. The codes mean 00 off, 01 75 ohm, 10 150 ohm, 11 50 ohm.
- R4: `init_done` is high for exactly one cycle, MRD cycles after the `emr_load` cycle.
- R5: An `init_req` seen from the `emr_load` cycle up to the cycle before `init_done` is ignored: no second load, and the done timing is unchanged.
- R6: Before the first `init_done`, `odt_en` stays low and read or write commands have no effect.
- R7: A write accepted in cycle t (no reads nearby) drives `odt_en` high exactly in cycles t+WL-lead through t+WL+BL/2+tail-1, where lead = `cfg_lead` (lead < WL and lead < CL) and tail = `cfg_tail`.
- R8: Writes spaced BL/2 cycles apart keep `odt_en` continuously high from the first window start to the last window end.
- R9: A read accepted in cycle t forces `odt_en` low in cycles t+CL-lead through t+CL+BL/2-1, overriding any write window, including one still in its tail.
- R10: Reads never raise `odt_en`.
- R11: During a re-initialisation load (the `emr_load` cycle through the cycle before `init_done`), `odt_en` is low and commands are ignored. Write windows that were already running resume once the load ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A read or write command is issued this cycle |
| cmd_is_wr | input | 1 | 1 = write, 0 = read, qualified by cmd_valid |
| init_req | input | 1 | Request to program the extended mode register |
| rtt_sel | input | 2 | Termination resistance code (see R3) |
| cfg_lead | input | CW | Cycles of enable ahead of the first write beat |
| cfg_tail | input | CW | Cycles of enable kept after the last write beat |
| odt_en | output | 1 | Termination enable to the memory device |
| emr_load | output | 1 | One-cycle extended-mode-register load strobe |
| emr_word | output | 16 | Bank-select and address word for the load |
| init_done | output | 1 | One-cycle completion pulse of the load |

## Verification
The bench sweeps every legal lead against a range of tails. The start and end of each enable window are therefore pinned at every offset. A design that counted the lead from the wrong side, or dropped it from the hold length, would be early or late at one end of the window. Back-to-back writes catch a timer that restarts instead of extending, which would leave a one-cycle gap. A read that follows a write one burst later must cut the write's tail before the read data arrives; a design that let the write window win would drive termination against the device's own output. Repeated initialisation requests during a load, commands before and during a load, and all four resistance codes expose loaders that re-trigger, leak the enable early, or swap bits 6 and 2.

// File: rtl/tes_pkg.sv
package tes_pkg;

  localparam int WORD_W = 16;
  localparam logic [1:0] EXT_REG_SEL = 2'b01;

  typedef enum logic [1:0] {
    LD_COLD  = 2'b00,
    LD_BUSY  = 2'b01,
    LD_READY = 2'b10
  } ld_state_e;

  // Build the extended-mode-register word: register select in the top two
  // bits, resistance code split over bit 6 (high) and bit 2 (low).
  function automatic logic [WORD_W-1:0] emr_encode(input logic [1:0] code);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[15:14] = EXT_REG_SEL;
    w[6]     = code[1];
    w[2]     = code[0];
    return w;
  endfunction

endpackage

// File: rtl/tes_emr_loader.sv
module tes_emr_loader
  import tes_pkg::*;
#(
  parameter int MRD = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_req_i,
  input  logic [1:0]        rtt_sel_i,
  output logic              load_o,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              ready_o,
  output logic              ok_next_o
);

  localparam int CNT_W = $clog2(MRD + 1);

  ld_state_e        st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             accept;
  logic             done_n;

  assign accept = init_req_i && (st_q != LD_BUSY);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    done_n = 1'b0;
    if (accept) begin
      st_n  = LD_BUSY;
      cnt_n = CNT_W'(MRD);
    end else if (st_q == LD_BUSY) begin
      if (cnt_q == CNT_W'(1)) begin
        st_n   = LD_READY;
        done_n = 1'b1;
      end else begin
        cnt_n = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= LD_COLD;
      cnt_q  <= '0;
      load_o <= 1'b0;
      word_o <= '0;
      done_o <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      load_o <= accept;
      done_o <= done_n;
      if (accept) word_o <= emr_encode(rtt_sel_i);
    end
  end

  assign busy_o    = (st_q == LD_BUSY);
  assign ready_o   = (st_q == LD_READY);
  assign ok_next_o = (st_n == LD_READY);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R4
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (rst)
    (busy_o && init_req_i) |=> !load_o); // R5
  AST_LOAD_MARKS_BUSY: assert property (@(posedge clk) disable iff (rst)
    load_o |-> busy_o); // R2

endmodule

// File: rtl/tes_strobe_delay.sv
module tes_strobe_delay #(
  parameter int DEPTH = 4,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_i,
  input  logic [SEL_W-1:0] tap_i,
  output logic             hit_o
);

  logic [DEPTH-1:0] line_q;
  logic [DEPTH:0]   taps;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= strobe_i;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= {line_q[DEPTH-2:0], strobe_i};
      end
    end
  endgenerate

  // taps[i] is the strobe as it was i cycles ago
  assign taps = {line_q, strobe_i};

  always_comb begin
    hit_o = 1'b0;
    for (int i = 0; i <= DEPTH; i++) begin
      if (tap_i == SEL_W'(i)) hit_o = taps[i];
    end
  end

endmodule

// File: rtl/tes_window_timer.sv
module tes_window_timer #(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             act_o,
  output logic             act_next_o
);

  logic [LEN_W-1:0] rem_q, rem_n;

  // A new start reloads the remaining length, so overlapping windows merge.
  always_comb begin
    if (start_i)            rem_n = len_i;
    else if (rem_q != '0)   rem_n = rem_q - LEN_W'(1);
    else                    rem_n = rem_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rem_q <= '0;
    else     rem_q <= rem_n;
  end

  assign act_o      = (rem_q != '0);
  assign act_next_o = (rem_n != '0);

  AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
    (act_o && !start_i) |=> (rem_q == $past(rem_q) - LEN_W'(1))); // R7

endmodule

// File: rtl/term_enable_seq.sv
module term_enable_seq
  import tes_pkg::*;
#(
  parameter int CL        = 5,
  parameter int WL        = 4,
  parameter int BURST_LEN = 4,
  parameter int MRD       = 3,
  parameter int CW        = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_is_wr,
  input  logic              init_req,
  input  logic [1:0]        rtt_sel,
  input  logic [CW-1:0]     cfg_lead,
  input  logic [CW-1:0]     cfg_tail,
  output logic              odt_en,
  output logic              emr_load,
  output logic [WORD_W-1:0] emr_word,
  output logic              init_done
);

  localparam int BC     = BURST_LEN / 2;
  localparam int MAX_LT = (WL > CL) ? WL : CL;
  localparam int DL     = MAX_LT - 1;
  localparam int TAP_W  = ($clog2(DL + 1) < 1) ? 1 : $clog2(DL + 1);
  localparam int LEN_W  = $clog2(2 * (1 << CW) + BC + 1);

  logic             ld_busy, ld_ready, ld_ok_next;
  logic             cmd_ok, wr_acc, rd_acc;
  logic [TAP_W-1:0] w_tap, r_tap;
  logic             w_start, r_start;
  logic [LEN_W-1:0] w_len, r_len;
  logic             w_act, w_act_n, r_act, r_act_n;
  logic             odt_q;

  tes_emr_loader #(.MRD(MRD)) u_loader (
    .clk        (clk),
    .rst        (rst),
    .init_req_i (init_req),
    .rtt_sel_i  (rtt_sel),
    .load_o     (emr_load),
    .word_o     (emr_word),
    .done_o     (init_done),
    .busy_o     (ld_busy),
    .ready_o    (ld_ready),
    .ok_next_o  (ld_ok_next)
  );

  assign cmd_ok = ld_ready && !ld_busy;
  assign wr_acc = cmd_valid && cmd_is_wr && cmd_ok;
  assign rd_acc = cmd_valid && !cmd_is_wr && cmd_ok;

  // A start seen in cycle c opens the window in cycle c+1, hence the minus one.
  assign w_tap = TAP_W'(WL - 1 - int'(cfg_lead));
  assign r_tap = TAP_W'(CL - 1 - int'(cfg_lead));
  assign w_len = LEN_W'(cfg_lead) + LEN_W'(BC) + LEN_W'(cfg_tail);
  assign r_len = LEN_W'(cfg_lead) + LEN_W'(BC);

  tes_strobe_delay #(.DEPTH(DL), .SEL_W(TAP_W)) u_wr_dly (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (wr_acc),
    .tap_i    (w_tap),
    .hit_o    (w_start)
  );

  tes_strobe_delay #(.DEPTH(DL), .SEL_W(TAP_W)) u_rd_dly (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (rd_acc),
    .tap_i    (r_tap),
    .hit_o    (r_start)
  );

  tes_window_timer #(.LEN_W(LEN_W)) u_wr_win (
    .clk        (clk),
    .rst        (rst),
    .start_i    (w_start),
    .len_i      (w_len),
    .act_o      (w_act),
    .act_next_o (w_act_n)
  );

  tes_window_timer #(.LEN_W(LEN_W)) u_rd_blank (
    .clk        (clk),
    .rst        (rst),
    .start_i    (r_start),
    .len_i      (r_len),
    .act_o      (r_act),
    .act_next_o (r_act_n)
  );

  always_ff @(posedge clk) begin
    if (rst) odt_q <= 1'b0;
    else     odt_q <= w_act_n && !r_act_n && ld_ok_next;
  end

  assign odt_en = odt_q;

  AST_EMR_FIELDS: assert property (@(posedge clk) disable iff (rst)
    emr_load |-> (emr_word[15:14] == 2'b01 && (emr_word & 16'h3FBB) == 16'h0000)); // R2
  AST_COLD_NO_ODT: assert property (@(posedge clk) disable iff (rst)
    (!ld_ready && !ld_busy) |-> !odt_en); // R6
  AST_LOAD_NO_ODT: assert property (@(posedge clk) disable iff (rst)
    ld_busy |-> !odt_en); // R11
  AST_ODT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    odt_en |-> w_act); // R7
  AST_READ_BLANK: assert property (@(posedge clk) disable iff (rst)
    r_act |-> !odt_en); // R9
  AST_LEAD_FITS: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (int'(cfg_lead) < WL && int'(cfg_lead) < CL)); // R7

endmodule

// File: tb/sim_term_enable_seq.sv
module sim_term_enable_seq;

  localparam int CLK_P = 10;
  localparam int CL    = 5;
  localparam int WL    = 4;
  localparam int BL    = 4;
  localparam int BC    = BL / 2;
  localparam int MRD   = 3;
  localparam int CW    = 3;
  localparam int NC    = 8192;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_is_wr = 1'b0;
  logic          init_req = 1'b0;
  logic [1:0]    rtt_sel = 2'b00;
  logic [CW-1:0] cfg_lead = '0;
  logic [CW-1:0] cfg_tail = '0;
  logic          odt_en, emr_load, init_done;
  logic [15:0]   emr_word;

  term_enable_seq #(.CL(CL), .WL(WL), .BURST_LEN(BL), .MRD(MRD), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_is_wr(cmd_is_wr),
    .init_req(init_req), .rtt_sel(rtt_sel), .cfg_lead(cfg_lead), .cfg_tail(cfg_tail),
    .odt_en(odt_en), .emr_load(emr_load), .emr_word(emr_word), .init_done(init_done)
  );

  always #(CLK_P / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  bit          on_a    [NC];
  bit          blank_a [NC];
  bit          busy_a  [NC];
  bit          load_a  [NC];
  bit          done_a  [NC];
  logic [15:0] word_a  [NC];
  int          first_ready = 1 << 30;
  int          lead = 0;
  int          tail = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          chk_en = 1'b0;
  string       tag = "R1";

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  // Continuous comparison of every output against the bench model.
  always @(negedge clk) begin
    if (chk_en && cyc < NC) begin
      chk(tag, "odt_en", {15'd0, odt_en}, {15'd0, on_a[cyc] & ~blank_a[cyc] & ~busy_a[cyc]});
      chk(tag, "emr_load", {15'd0, emr_load}, {15'd0, load_a[cyc]});
      chk(tag, "init_done", {15'd0, init_done}, {15'd0, done_a[cyc]});
      if (load_a[cyc]) chk("R3", "emr_word", emr_word, word_a[cyc]);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input int l, input int t);
    lead = l; tail = t;
    cfg_lead = CW'(l); cfg_tail = CW'(t);
  endtask

  task automatic cmd(input bit wr);
    int t;
    t = cyc;
    cmd_valid = 1'b1;
    cmd_is_wr = wr;
    if (t >= first_ready && !busy_a[t]) begin
      if (wr) for (int c = t + WL - lead; c <= t + WL + BC + tail - 1; c++) on_a[c] = 1'b1;
      else    for (int c = t + CL - lead; c <= t + CL + BC - 1; c++) blank_a[c] = 1'b1;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic init(input logic [1:0] sel);
    int k;
    logic [15:0] w;
    k = cyc;
    init_req = 1'b1;
    rtt_sel = sel;
    if (!busy_a[k]) begin
      w = 16'h4000; w[6] = sel[1]; w[2] = sel[0];
      load_a[k + 1] = 1'b1;
      word_a[k + 1] = w;
      for (int c = k + 1; c <= k + MRD; c++) busy_a[c] = 1'b1;
      done_a[k + 1 + MRD] = 1'b1;
      if (first_ready > k + 1 + MRD) first_ready = k + 1 + MRD;
    end
    @(negedge clk);
    init_req = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(posedge clk);
    chk_en = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: first cycle out of reset
    chk("R1", "odt_en", {15'd0, odt_en}, 16'd0);
    chk("R1", "emr_load", {15'd0, emr_load}, 16'd0);

    // R6: commands before initialisation have no effect
    tag = "R6";
    set_cfg(1, 1);
    cmd(1'b1); cmd(1'b1); cmd(1'b0);
    idle(14);

    // R2, R4, R5: load with a second request during the load
    tag = "R5";
    init(2'b10);
    idle(1);
    init(2'b01);
    init(2'b11);
    idle(8);

    // R3: every resistance code, checked in the emr_word field positions
    tag = "R3";
    for (int s = 0; s < 4; s++) begin
      init(2'(s));
      idle(MRD + 2);
    end

    // R7: single writes over every legal lead and a range of tails
    tag = "R7";
    for (int l = 0; l < 4; l++) begin
      for (int t = 0; t < 6; t++) begin
        set_cfg(l, t);
        idle(1);
        cmd(1'b1);
        idle(WL + BC + t + 3);
      end
    end

    // R8: back-to-back writes one burst apart
    tag = "R8";
    for (int l = 0; l < 4; l++) begin
      for (int t = 0; t < 3; t++) begin
        set_cfg(l, t);
        idle(1);
        cmd(1'b1); idle(BC - 1);
        cmd(1'b1); idle(BC - 1);
        cmd(1'b1);
        idle(20);
      end
    end

    // R9: read one burst after a write cuts the write tail
    tag = "R9";
    for (int l = 0; l < 4; l++) begin
      for (int t = 0; t < 5; t++) begin
        set_cfg(l, t);
        idle(1);
        cmd(1'b1); idle(BC - 1);
        cmd(1'b0);
        idle(20);
      end
    end

    // R10: reads alone and back-to-back reads never raise the enable
    tag = "R10";
    for (int l = 0; l < 4; l++) begin
      set_cfg(l, 2);
      idle(1);
      cmd(1'b0); idle(BC - 1); cmd(1'b0);
      idle(14);
    end

    // R11: re-initialisation during a write window, writes during the load
    tag = "R11";
    set_cfg(0, 5);
    idle(1);
    cmd(1'b1);
    idle(3);
    init(2'b01);
    cmd(1'b1);
    cmd(1'b1);
    idle(24);

    chk_en = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule